// File: doc/BRIEF.md
# Power-Up Test Mode Qualifier

This block sits in front of a cell-protection controller and decides, once per power-up, whether that controller runs with its normal timing or with shortened quick-test timing. It watches a regulator-good flag, the level of an external control pin and a free-running millisecond tick. Cell monitoring is enabled as soon as the regulator is good. If the control pin is already low at that moment and stays low for a qualification window, the block raises a test-mode flag. While that flag is set, the downstream controller uses 100 ms for its monitor cycle, its detection delay and its release delay.

The qualification window is a parameter counted in ticks (25 ticks by default, which is inside the accepted 15 to 35 ms range). Test mode is left only by a release-then-reassert sequence on the same pin: the pin goes high, which keeps test mode, and the next low returns the block to normal mode. In normal mode a low pin only stands for an emulated alarm for the downstream logic, and it never brings test mode back. Losing the regulator-good flag disables monitoring, clears test mode and rearms the whole power-up decision.

Top module: `pwrup_testmode_qual`

## Requirements
- R1: During and right after reset, test_mode_o and mon_en_o are both 0.
- R2: mon_en_o is 0 in the cycle after any cycle with reg_good_i low, and 1 in the cycle after any cycle with reg_good_i high.
- R3: With the pin low (ctrl_n_i = 0) when reg_good_i rises and kept low, test_mode_o goes to 1 after QUAL_TICKS tick pulses, and stays 0 while fewer than QUAL_TICKS pulses have arrived.
- R4: If the pin goes high before QUAL_TICKS tick pulses have arrived, qualification is abandoned and test_mode_o stays 0 until reg_good_i falls and rises again.
- R5: If the pin is high when reg_good_i rises, the block is in normal mode; later lows on the pin, however long, leave test_mode_o at 0.
- R6: In test mode, the pin going high keeps test_mode_o at 1; the next low on the pin clears test_mode_o, and the block then stays in normal mode.
- R7: reg_good_i going low clears test_mode_o in the next cycle; when it returns, qualification starts again from zero ticks.
- R8: ctrl_n_i passes through a two-flop synchroniser: a level change applied before a clock edge reaches test_mode_o after the third rising edge, not earlier.
- R9: test_mode_o is never 1 while mon_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_good_i | input | 1 | Regulator above its recovery threshold (synchronous) |
| ctrl_n_i | input | 1 | Asynchronous control pin level, low active |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| test_mode_o | output | 1 | Quick test timing selected |
| mon_en_o | output | 1 | Cell monitoring enabled |

## Verification
The checker watches every cycle that monitoring follows the regulator-good flag with one cycle of delay, that a loss of that flag clears the test flag, that the test flag never stands without monitoring and that test mode never starts in the very cycle monitoring does. The tick counting of the entry window, the abandon path, the release-then-reassert exit and the inability of normal mode to re-enter test mode depend on pin history across many cycles, so only the bench scenarios show them, together with the exact synchroniser latency.

// File: rtl/tqm_pkg.sv
package tqm_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,  // regulator not good, everything held off
    ST_QUAL = 3'd1,  // pin held low, counting ticks
    ST_NORM = 3'd2,  // normal timing until next power-up
    ST_TEST = 3'd3,  // quick test timing, pin still low
    ST_TREL = 3'd4   // quick test timing, pin released, waiting for low
  } tq_state_e;

  function automatic logic is_test(tq_state_e s);
    return (s == ST_TEST) || (s == ST_TREL);
  endfunction

endpackage

// File: rtl/tqm_sync.sv
module tqm_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RST_VAL;
          else     chain_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RST_VAL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tqm_tick_timer.sv
module tqm_tick_timer #(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q == LIM);

endmodule

// File: rtl/tqm_mode_fsm.sv
module tqm_mode_fsm
  import tqm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic reg_good_i,
  input  logic ctrl_low_i,
  input  logic qual_done_i,
  output logic qual_run_o,
  output logic test_mode_o,
  output logic mon_en_o
);

  tq_state_e st_q, st_d;
  logic      test_q, mon_q;

  always_comb begin
    st_d = st_q;
    if (!reg_good_i) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:  st_d = ctrl_low_i ? ST_QUAL : ST_NORM;
        ST_QUAL: begin
          if (!ctrl_low_i)      st_d = ST_NORM;
          else if (qual_done_i) st_d = ST_TEST;
        end
        ST_TEST: if (!ctrl_low_i) st_d = ST_TREL;
        ST_TREL: if (ctrl_low_i)  st_d = ST_NORM;
        ST_NORM: st_d = ST_NORM;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_OFF;
      test_q <= 1'b0;
      mon_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      test_q <= is_test(st_d);
      mon_q  <= (st_d != ST_OFF);
    end
  end

  assign qual_run_o  = (st_q == ST_QUAL);
  assign test_mode_o = test_q;
  assign mon_en_o    = mon_q;

endmodule

// File: rtl/pwrup_testmode_qual.sv
module pwrup_testmode_qual #(
  parameter int QUAL_TICKS  = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic reg_good_i,
  input  logic ctrl_n_i,
  input  logic tick_i,
  output logic test_mode_o,
  output logic mon_en_o
);

  logic ctrl_n_s;
  logic qual_run;
  logic qual_done;

  // Pin idles high, so the synchroniser resets to high.
  tqm_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(ctrl_n_i),
    .q_o(ctrl_n_s)
  );

  tqm_tick_timer #(
    .LIMIT(QUAL_TICKS)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run_i (qual_run),
    .tick_i(tick_i),
    .done_o(qual_done)
  );

  tqm_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .reg_good_i (reg_good_i),
    .ctrl_low_i (!ctrl_n_s),
    .qual_done_i(qual_done),
    .qual_run_o (qual_run),
    .test_mode_o(test_mode_o),
    .mon_en_o   (mon_en_o)
  );

endmodule

// File: rtl/pwrup_testmode_qual_chk.sv
module pwrup_testmode_qual_chk (
  input logic clk,
  input logic rst,
  input logic reg_good_i,
  input logic test_mode_o,
  input logic mon_en_o
);

  a_r2_mon_off: assert property (@(posedge clk) disable iff (rst)
    !reg_good_i |=> !mon_en_o);

  a_r2_mon_on: assert property (@(posedge clk) disable iff (rst)
    reg_good_i |=> mon_en_o);

  a_r7_drop_clears_test: assert property (@(posedge clk) disable iff (rst)
    !reg_good_i |=> !test_mode_o);

  a_r9_test_needs_mon: assert property (@(posedge clk) disable iff (rst)
    test_mode_o |-> mon_en_o);

  a_r3_entry_after_qual: assert property (@(posedge clk) disable iff (rst)
    $rose(test_mode_o) |-> $past(mon_en_o));

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!test_mode_o && !mon_en_o));

endmodule

bind pwrup_testmode_qual pwrup_testmode_qual_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_good_i (reg_good_i),
  .test_mode_o(test_mode_o),
  .mon_en_o   (mon_en_o)
);

// File: tb/pwrup_testmode_qual_tb.sv
module pwrup_testmode_qual_tb;

  localparam int QT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_good = 1'b0;
  logic ctrl_n = 1'b1;
  logic tick = 1'b0;
  logic test_mode, mon_en;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwrup_testmode_qual #(.QUAL_TICKS(QT), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .reg_good_i(reg_good), .ctrl_n_i(ctrl_n),
    .tick_i(tick), .test_mode_o(test_mode), .mon_en_o(mon_en)
  );

  // Row: [8] pin low at power-up, [7:1] ticks while low, [0] expected test flag
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 7'd10, 1'b1},
    {1'b1, 7'd5,  1'b1},
    {1'b1, 7'd4,  1'b0},
    {1'b1, 7'd2,  1'b0},
    {1'b0, 7'd0,  1'b0},
    {1'b0, 7'd8,  1'b0}
  };

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(1);
      tick = 1'b0; cyc(3);
    end
  endtask

  task automatic do_reset();
    reg_good = 1'b0; tick = 1'b0;
    rst = 1'b1; cyc(3);
    rst = 1'b0; cyc(1);
  endtask

  initial begin
    cyc(2);
    // R1: reset state
    check("R1 test", test_mode, 1'b0);
    check("R1 mon", mon_en, 1'b0);
    do_reset();
    check("R1 test after release", test_mode, 1'b0);
    // R2: monitoring follows regulator-good one cycle later
    cyc(3);
    check("R2 mon off", mon_en, 1'b0);
    reg_good = 1'b1; cyc(1);
    check("R2 mon on", mon_en, 1'b1);
    reg_good = 1'b0; cyc(1);
    check("R2 mon drop", mon_en, 1'b0);

    foreach (VEC[k]) begin
      logic lo0, ex;
      int nt;
      lo0 = VEC[k][8]; nt = int'(VEC[k][7:1]); ex = VEC[k][0];
      do_reset();
      ctrl_n = !lo0; cyc(5);
      reg_good = 1'b1; cyc(2);
      if (lo0) begin
        pulse_ticks(nt);
      end else begin
        ctrl_n = 1'b0;  // R5: low after power-up only, in normal mode
        pulse_ticks(nt);
      end
      cyc(6);
      check(ex ? "R3 entered" : "R4/R5 not entered", test_mode, ex);
      ctrl_n = 1'b1; cyc(6); pulse_ticks(2);
      check(ex ? "R6 release holds" : "R4 release stays normal", test_mode, ex);
      ctrl_n = 1'b0; cyc(6);
      check("R6 reassert exits", test_mode, 1'b0);
      pulse_ticks(QT + 2);
      check("R5 normal low ignored", test_mode, 1'b0);
      check("R2 mon kept", mon_en, 1'b1);
    end

    // R3 boundary: one tick short then the last tick
    do_reset();
    ctrl_n = 1'b0; cyc(5);
    reg_good = 1'b1; cyc(2);
    pulse_ticks(QT - 1); cyc(4);
    check("R3 one short", test_mode, 1'b0);
    pulse_ticks(1); cyc(2);
    check("R3 last tick", test_mode, 1'b1);

    // R7: regulator drop clears and qualification restarts from zero
    reg_good = 1'b0; cyc(1);
    check("R7 drop clears test", test_mode, 1'b0);
    check("R7 drop clears mon", mon_en, 1'b0);
    cyc(3);
    reg_good = 1'b1; cyc(2);
    pulse_ticks(QT - 1); cyc(4);
    check("R7 restart from zero", test_mode, 1'b0);
    pulse_ticks(1); cyc(2);
    check("R7 re-entered", test_mode, 1'b1);

    // R8: synchroniser latency on the exit sequence
    ctrl_n = 1'b1; cyc(6);
    ctrl_n = 1'b0;
    cyc(2);
    check("R8 two edges still set", test_mode, 1'b1);
    cyc(1);
    check("R8 third edge clears", test_mode, 1'b0);
    check("R9 mon stays", mon_en, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule